// File: doc/BRIEF.md
# Interrupt Aggregator for Periodic, Alarm and Timer Events

This block turns three timekeeping events into one active-low interrupt line, meant to drive an open-drain pin. The events are a periodic pulse, a match between programmed alarm fields and the running clock, and a rollover of the elapsed-time counter. Each event has its own enable bit, a sticky flag and a mask bit. The line is asserted whenever a flag is set and its mask is set.

The clock counters and the bus interface are outside the block. The clock arrives as packed BCD bytes together with a one-cycle strobe that marks each 10 ms update. The timer rollover arrives as a one-cycle strobe. Software acknowledges an event by writing the flag/mask register, and reads flags and masks back through a status output.

A standby input models the power-fail state. In standby the pulse source stops and only the alarm is allowed to pull the line low.

Top module: `event_irq_unit`

## Requirements
- R1: While rst_ni is low, status_o reads 0x00 and irq_no is high.
- R2: Outside standby, irq_no is low exactly when, for some source, both its flag and its mask are set. status_o carries the timer flag in bit 6, the alarm flag in bit 5 and the pulse flag in bit 4. It carries the timer mask in bit 2, the alarm mask in bit 1 and the pulse mask in bit 0. Bits 7 and 3 read 0.
- R3: A cycle with flag_wr_i high loads the masks from flag_wdata_i bits 2..0. In that same cycle, each flag whose bit in flag_wdata_i (bits 6..4) is 0 is cleared, and each flag whose bit is 1 keeps its value.
- R4: When a flag's set event and a clearing write fall in the same cycle, the flag ends up set.
- R5: On a tick_i cycle with the alarm enabled (ctrl_i bit 2), the alarm flag is set when each of the date, hours, minutes, seconds and hundredths alarm bytes equals its live clock byte.
- R6: An alarm byte of 0xFF takes no part in the compare. That field always counts as matching.
- R7: The alarm flag is set only on the first tick of a run of consecutive matching ticks. A flag cleared during such a run stays clear until a tick without a match is followed by a matching one.
- R8: With the pulse enabled (ctrl_i bit 1), pulse_sel_i picks the period. 0001 means every tick. 0010 means a tick where the hundredths units digit is 0. 0100 means a tick where the hundredths byte is 00. 1000 means a tick where both the hundredths and seconds bytes are 00. The pulse flag is set on each qualifying tick.
- R9: When pulse_sel_i is not one-hot (zero, or more than one bit set), the pulse flag is never set.
- R10: With the timer enabled (ctrl_i bit 3), a tmr_wrap_i cycle sets the timer flag.
- R11: In standby, only the alarm flag together with its mask can drive irq_no low. No pulse flag is set in standby. Timer and alarm flags still set, and once standby ends they resume driving irq_no according to R2.
- R12: A source whose enable bit is 0 never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe for each 10 ms clock update |
| tmr_wrap_i | input | 1 | One-cycle strobe when the timer wraps to zero |
| standby_i | input | 1 | Power-fail standby state |
| ctrl_i | input | 8 | Enable bits: timer 3, alarm 2, pulse 1 |
| pulse_sel_i | input | 4 | One-hot pulse period select |
| now_cs_i | input | 8 | Live clock hundredths (BCD) |
| now_sec_i | input | 8 | Live clock seconds (BCD) |
| now_min_i | input | 8 | Live clock minutes (BCD) |
| now_hr_i | input | 8 | Live clock hours (BCD) |
| now_date_i | input | 8 | Live clock date (BCD) |
| alm_cs_i | input | 8 | Alarm hundredths, 0xFF = wildcard |
| alm_sec_i | input | 8 | Alarm seconds, 0xFF = wildcard |
| alm_min_i | input | 8 | Alarm minutes, 0xFF = wildcard |
| alm_hr_i | input | 8 | Alarm hours, 0xFF = wildcard |
| alm_date_i | input | 8 | Alarm date, 0xFF = wildcard |
| flag_wr_i | input | 1 | Write strobe for the flag/mask register |
| flag_wdata_i | input | 8 | Write data: flag clear bits 6..4, masks 2..0 |
| status_o | output | 8 | Flags in bits 6..4, masks in bits 2..0 |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Every flag and mask change takes effect at the clock edge that samples tick_i, tmr_wrap_i or flag_wr_i, so status_o shows it one edge after the stimulus. irq_no is combinational from the registered flags, masks and standby_i. It therefore settles in that same cycle and follows standby_i without delay. The bench drives inputs and samples outputs 5 ns after each rising edge. It updates its reference model exactly once per edge, using the inputs that were present at that edge. Sampling is thus always one register stage after the stimulus.

// File: rtl/event_irq_pkg.sv
package event_irq_pkg;
  localparam int unsigned BCD_W    = 8;
  localparam int unsigned N_FIELD  = 5;
  localparam int unsigned N_SRC    = 3;
  localparam int unsigned N_PSEL   = 4;
  localparam int unsigned EN_LSB   = 1;
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned MASK_LSB = 0;
  localparam logic [BCD_W-1:0] WILDCARD = {BCD_W{1'b1}};

  typedef enum int unsigned {
    SRC_PULSE = 0,
    SRC_ALARM = 1,
    SRC_TIMER = 2
  } src_e;

  typedef enum int unsigned {
    F_CS = 0, F_SEC = 1, F_MIN = 2, F_HR = 3, F_DATE = 4
  } field_e;

  typedef logic [N_FIELD-1:0][BCD_W-1:0] time_vec_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import event_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      en_i,
  input  time_vec_t now_i,
  input  time_vec_t alarm_i,
  output logic      hit_o
);
  logic [N_FIELD-1:0] field_ok;
  logic match, match_q;

  for (genvar i = 0; i < N_FIELD; i++) begin : g_field
    assign field_ok[i] = (alarm_i[i] == WILDCARD) || (alarm_i[i] == now_i[i]);
  end

  assign match = en_i & (&field_ok);

  // match state only advances on update ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_q <= 1'b0;
    else if (tick_i) match_q <= match;
  end

  assign hit_o = tick_i & match & ~match_q;
endmodule

// File: rtl/pulse_select.sv
module pulse_select
  import event_irq_pkg::*;
(
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              standby_i,
  input  logic [N_PSEL-1:0] sel_i,
  input  logic [BCD_W-1:0]  cs_i,
  input  logic [BCD_W-1:0]  sec_i,
  output logic              hit_o
);
  localparam int unsigned DIGIT_W = BCD_W / 2;

  logic [N_PSEL-1:0] boundary;
  logic sel_valid;

  assign boundary[0] = 1'b1;
  assign boundary[1] = (cs_i[DIGIT_W-1:0] == '0);
  assign boundary[2] = (cs_i == '0);
  assign boundary[3] = (cs_i == '0) && (sec_i == '0);

  assign sel_valid = (sel_i != '0) && ((sel_i & (sel_i - 1'b1)) == '0);
  assign hit_o     = tick_i & en_i & ~standby_i & sel_valid & (|(sel_i & boundary));
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import event_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] keep_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             standby_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_no
);
  logic [N_SRC-1:0] active;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam bit STBY_OK = (i == int'(SRC_ALARM));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[i] <= 1'b0;
        mask_o[i] <= 1'b0;
      end else begin
        if (set_i[i])  flag_o[i] <= 1'b1;
        else if (wr_i) flag_o[i] <= flag_o[i] & keep_i[i];
        if (wr_i)      mask_o[i] <= mask_wdata_i[i];
      end
    end

    assign active[i] = flag_o[i] & mask_o[i] & (STBY_OK | ~standby_i);
  end

  assign irq_no = ~(|active);
endmodule

// File: rtl/event_irq_unit.sv
module event_irq_unit
  import event_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tmr_wrap_i,
  input  logic             standby_i,
  input  logic [7:0]       ctrl_i,
  input  logic [3:0]       pulse_sel_i,
  input  logic [7:0]       now_cs_i,
  input  logic [7:0]       now_sec_i,
  input  logic [7:0]       now_min_i,
  input  logic [7:0]       now_hr_i,
  input  logic [7:0]       now_date_i,
  input  logic [7:0]       alm_cs_i,
  input  logic [7:0]       alm_sec_i,
  input  logic [7:0]       alm_min_i,
  input  logic [7:0]       alm_hr_i,
  input  logic [7:0]       alm_date_i,
  input  logic             flag_wr_i,
  input  logic [7:0]       flag_wdata_i,
  output logic [7:0]       status_o,
  output logic             irq_no
);
  time_vec_t        now_v, alm_v;
  logic [N_SRC-1:0] en, set, flag, mask;

  assign now_v[F_CS]   = now_cs_i;
  assign now_v[F_SEC]  = now_sec_i;
  assign now_v[F_MIN]  = now_min_i;
  assign now_v[F_HR]   = now_hr_i;
  assign now_v[F_DATE] = now_date_i;
  assign alm_v[F_CS]   = alm_cs_i;
  assign alm_v[F_SEC]  = alm_sec_i;
  assign alm_v[F_MIN]  = alm_min_i;
  assign alm_v[F_HR]   = alm_hr_i;
  assign alm_v[F_DATE] = alm_date_i;

  assign en = ctrl_i[EN_LSB +: N_SRC];

  pulse_select u_pulse (
    .tick_i    (tick_i),
    .en_i      (en[SRC_PULSE]),
    .standby_i (standby_i),
    .sel_i     (pulse_sel_i),
    .cs_i      (now_cs_i),
    .sec_i     (now_sec_i),
    .hit_o     (set[SRC_PULSE])
  );

  alarm_match u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (en[SRC_ALARM]),
    .now_i   (now_v),
    .alarm_i (alm_v),
    .hit_o   (set[SRC_ALARM])
  );

  assign set[SRC_TIMER] = tmr_wrap_i & en[SRC_TIMER];

  flag_bank u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set),
    .wr_i         (flag_wr_i),
    .keep_i       (flag_wdata_i[FLAG_LSB +: N_SRC]),
    .mask_wdata_i (flag_wdata_i[MASK_LSB +: N_SRC]),
    .standby_i    (standby_i),
    .flag_o       (flag),
    .mask_o       (mask),
    .irq_no       (irq_no)
  );

  always_comb begin
    status_o = '0;
    status_o[FLAG_LSB +: N_SRC] = flag;
    status_o[MASK_LSB +: N_SRC] = mask;
  end
endmodule

// File: rtl/event_irq_chk.sv
module event_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       tmr_wrap_i,
  input logic       standby_i,
  input logic [7:0] ctrl_i,
  input logic [3:0] pulse_sel_i,
  input logic       flag_wr_i,
  input logic [7:0] flag_wdata_i,
  input logic [7:0] status_o,
  input logic       irq_no
);
  // R1: reset state
  a_r1_reset_irq: assert property (@(posedge clk_i) !rst_ni |-> (irq_no && status_o == 8'h00));

  // R2: unmasked timer flag drives line outside standby
  a_r2_timer_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && status_o[6] && status_o[2]) |-> !irq_no);

  // R3: write of 0 clears the alarm flag when no tick can set it
  a_r3_alarm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !flag_wdata_i[5] && !tick_i) |=> !status_o[5]);

  // R3: flags are sticky without a clearing write
  a_r3_timer_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] && !(flag_wr_i && !flag_wdata_i[6])) |=> status_o[6]);

  // R9: invalid select never raises the pulse flag
  a_r9_bad_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pulse_sel_i) != 1 && !status_o[4]) |=> !status_o[4]);

  // R10: timer flag rises only on a wrap strobe
  a_r10_timer_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_wrap_i && !status_o[6]) |=> !status_o[6]);

  // R11: standby with alarm flag clear keeps line high; pulse stays clear
  a_r11_stby_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && !status_o[5]) |-> irq_no);
  a_r11_stby_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && !status_o[4]) |=> !status_o[4]);

  // R12: disabled pulse never sets
  a_r12_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[1] && !status_o[4]) |=> !status_o[4]);
endmodule

bind event_irq_unit event_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .tmr_wrap_i   (tmr_wrap_i),
  .standby_i    (standby_i),
  .ctrl_i       (ctrl_i),
  .pulse_sel_i  (pulse_sel_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .status_o     (status_o),
  .irq_no       (irq_no)
);

// File: tb/tb_event_irq_unit.sv
module tb_event_irq_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, tick, wrap, stby, fwr;
  logic [7:0] ctrl, fwd, ncs, nsec, nmin, nhr, ndate, acs, asec, amin, ahr, adate;
  logic [3:0] sel;
  logic [7:0] status;
  logic       irq_n;

  int checks = 0, errors = 0;
  logic [2:0] m_flag, m_mask;
  logic       m_prev;

  event_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tmr_wrap_i(wrap), .standby_i(stby),
    .ctrl_i(ctrl), .pulse_sel_i(sel),
    .now_cs_i(ncs), .now_sec_i(nsec), .now_min_i(nmin), .now_hr_i(nhr), .now_date_i(ndate),
    .alm_cs_i(acs), .alm_sec_i(asec), .alm_min_i(amin), .alm_hr_i(ahr), .alm_date_i(adate),
    .flag_wr_i(fwr), .flag_wdata_i(fwd), .status_o(status), .irq_no(irq_n)
  );

  function automatic logic fok(logic [7:0] a, logic [7:0] c);
    return (a == 8'hFF) || (a == c);
  endfunction

  function automatic logic pulse_due();
    case (sel)
      4'b0001: return 1'b1;
      4'b0010: return ncs[3:0] == 4'h0;
      4'b0100: return ncs == 8'h00;
      4'b1000: return (ncs == 8'h00) && (nsec == 8'h00);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_irq_n();
    logic [2:0] act;
    act = m_flag & m_mask;
    if (stby) act = act & 3'b010;
    return ~(|act);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [2:0] set;
    logic am;
    am = ctrl[2] && fok(acs, ncs) && fok(asec, nsec) && fok(amin, nmin)
         && fok(ahr, nhr) && fok(adate, ndate);
    set[0] = tick && ctrl[1] && !stby && pulse_due();
    set[1] = tick && am && !m_prev;
    set[2] = wrap && ctrl[3];
    if (tick) m_prev = am;
    if (fwr) begin
      m_flag = (m_flag & fwd[6:4]) | set;
      m_mask = fwd[2:0];
    end else begin
      m_flag = m_flag | set;
    end
    @(posedge clk); #5;
    check({tag, " status"}, status, {1'b0, m_flag, 1'b0, m_mask});
    check({tag, " irq"}, irq_n, exp_irq_n());
    tick = 0; wrap = 0; fwr = 0;
  endtask

  function automatic logic [7:0] pick(input logic [7:0] a, b, c);
    case ($urandom % 3)
      0: return a;
      1: return b;
      default: return c;
    endcase
  endfunction

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; tick = 0; wrap = 0; stby = 0; fwr = 0; fwd = 0; ctrl = 0; sel = 0;
    ncs = 0; nsec = 0; nmin = 0; nhr = 0; ndate = 8'h01;
    acs = 8'hFF; asec = 8'hFF; amin = 8'hFF; ahr = 8'hFF; adate = 8'hFF;
    m_flag = 0; m_mask = 0; m_prev = 0;
    #35;
    check("R1 status", status, 8'h00);
    check("R1 irq", irq_n, 1'b1);
    @(posedge clk); #5; rst_n = 1;
    @(posedge clk); #5;

    // R12: everything disabled
    ctrl = 8'h00; sel = 4'b0001; tick = 1; wrap = 1; step("R12");
    check("R12 no flag", status[6:4], 3'b000);

    // R10 + R2: timer set with mask
    ctrl = 8'h08; fwr = 1; fwd = 8'h77; step("R3 mask load");
    wrap = 1; step("R10");
    check("R10 flag", status[6], 1'b1);
    check("R2 irq low", irq_n, 1'b0);

    // R4: set and clear together
    wrap = 1; fwr = 1; fwd = 8'h07; step("R4");
    check("R4 set wins", status[6], 1'b1);
    fwr = 1; fwd = 8'h07; step("R3 clear");
    check("R3 cleared", status[6], 1'b0);
    check("R2 irq high", irq_n, 1'b1);

    // R5/R6/R7: seconds-only alarm
    ctrl = 8'h04; asec = 8'h30; nsec = 8'h30; ncs = 8'h42;
    tick = 1; step("R5");
    check("R6 wildcard match", status[5], 1'b1);
    fwr = 1; fwd = 8'h57; step("R3 alarm clr");
    tick = 1; step("R7 hold");
    check("R7 no reset", status[5], 1'b0);
    nsec = 8'h31; tick = 1; step("R7 miss");
    nsec = 8'h30; tick = 1; step("R7 rematch");
    check("R7 new match", status[5], 1'b1);
    acs = 8'h43; nsec = 8'h31; tick = 1; step("R5 miss");
    fwr = 1; fwd = 8'h07; step("R5 clr");
    nsec = 8'h30; tick = 1; step("R5 cs mismatch");
    check("R5 cs compared", status[5], 1'b0);
    acs = 8'hFF;

    // R9: invalid select
    ctrl = 8'h02; ncs = 8'h00; nsec = 8'h00;
    sel = 4'b0011; tick = 1; step("R9 two bits");
    sel = 4'b0000; tick = 1; step("R9 zero");
    check("R9 no pulse", status[4], 1'b0);

    // R8: 100 ms boundary
    sel = 4'b0010; ncs = 8'h35; tick = 1; step("R8 off");
    check("R8 no pulse", status[4], 1'b0);
    ncs = 8'h40; tick = 1; step("R8 on");
    check("R8 pulse", status[4], 1'b1);

    // R11: standby
    fwr = 1; fwd = 8'h07; step("R11 clr");
    ctrl = 8'h0E; stby = 1; sel = 4'b0001; asec = 8'h59; nsec = 8'h00;
    tick = 1; wrap = 1; step("R11 stby");
    check("R11 timer flags", status[6], 1'b1);
    check("R11 pulse held", status[4], 1'b0);
    check("R11 irq gated", irq_n, 1'b1);
    nsec = 8'h59; tick = 1; step("R11 alarm");
    check("R11 alarm irq", irq_n, 1'b0);
    stby = 0; step("R11 exit");
    fwr = 1; fwd = 8'h07; step("R11 cleanup");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      wrap = ($urandom % 8) == 0;
      fwr  = ($urandom % 6) == 0;
      fwd  = 8'($urandom);
      stby = ($urandom % 8) == 0;
      ctrl = 8'($urandom);
      sel  = (($urandom % 4) == 0) ? 4'($urandom) : 4'(1 << ($urandom % 4));
      ncs  = pick(8'h00, 8'h20, 8'h57);
      nsec = pick(8'h00, 8'h15, 8'h30);
      nmin = pick(8'h00, 8'h10, 8'h10);
      acs  = pick(8'hFF, 8'h00, 8'h57);
      asec = pick(8'hFF, 8'h15, 8'h00);
      amin = pick(8'hFF, 8'hFF, 8'h10);
      ahr  = pick(8'hFF, 8'hFF, 8'h00);
      adate = 8'hFF;
      step("R2 R3 R5 R8 R10 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule